// File: doc/BRIEF.md
# Laser Detector Alarm Aggregator

This block collects the outputs of a field of light-sensitive detector cells and reduces them to one alarm flag that stays set until it is cleared. The cells sit in several chains. Each chain carries a disturbance from any of its cells to the chain's end. Two kinds of cell are supported. One kind rests low and pulses high when struck. The other rests high and pulses low. A per-cell parameter marks the low-active kind, and each cell's output is turned to active-high before it joins its chain. As a result, every chain rests at 0.

A strike can be far shorter than a clock period. For this reason, each chain end sets a capture latch without waiting for the clock. The latch is passed through two synchronising flops, and it releases itself once the synchronised copy has been seen. The synchronised chain signals drive a per-chain status register, which shows which chains fired. They are also merged through a NOR, which drives the alarm flop. A clear input empties both the alarm and the status, except for events that are arriving in the same cycle. A self-test input forces every chain active, so that the whole alarm path can be exercised.

Top module: `laser_alarm_agg`

## Requirements
- R1: While reset is low, and in the first cycle after it, `alarm_o` is 0 and `chain_status_o` is all zeros.
- R2: A high pulse on a cell whose bit in `CELL_ACTIVE_LOW` is 0 sets `alarm_o` and the status bit of its chain, where chain = cell index / `CELLS_PER_CHAIN`. Both are visible after the third rising clock edge that follows the pulse.
- R3: A low pulse on a cell whose bit in `CELL_ACTIVE_LOW` is 1 sets `alarm_o` and that chain's status bit, with the same latency as R2.
- R4: Cells held at their resting level never set `alarm_o` or any status bit. The resting level is 0 for the high-active kind and 1 for the low-active kind.
- R5: A pulse that starts and ends between two rising clock edges is still captured.
- R6: Once set, `alarm_o` and the status bits stay set while `clr_i` is low. A one-cycle `clr_i` with no event arriving returns both to 0 after that edge.
- R7: A clear that is sampled in the same cycle as an arriving chain event leaves `alarm_o` set, and it leaves the arriving chain's status bit set.
- R8: Each chain has its own status bit. Events on several chains at once set every one of their bits, and no other bits.
- R9: While `self_test_i` is high, every status bit and `alarm_o` become set.
- R10: `alarm_o` is at all times equal to the OR of the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_raw_i | input | NUM_CHAINS*CELLS_PER_CHAIN | Raw detector cell outputs. Cell k belongs to chain k / CELLS_PER_CHAIN |
| self_test_i | input | 1 | Forces every chain to its active level |
| clr_i | input | 1 | Synchronous clear of the alarm and the status |
| alarm_o | output | 1 | Sticky alarm flag |
| chain_status_o | output | NUM_CHAINS | Sticky record of which chains fired |

## Verification
The assertions assume that `clr_i` and `self_test_i` are synchronous to `clk`. Only the detector inputs may change at any time. The bench therefore changes `clr_i` and `self_test_i` on falling edges only. It places short detector pulses wholly between rising edges, so that no capture latch is set at the instant a clock edge samples it. The clean-clear assertion only constrains cycles in which no synchronised event is present. To match this, the bench waits until an event has fully drained through the synchronisers before it checks that a clear empties the flag. The one exception is the R7 test, which deliberately sets up the overlap of a clear with an arriving event.

// File: rtl/laser_alarm_pkg.sv
package laser_alarm_pkg;
  // Convert a raw cell value to active-high given its kind.
  function automatic logic cell_active(input logic raw, input logic active_low);
    return raw ^ active_low;
  endfunction

  // Next value of a sticky bit: arriving event wins over clear.
  function automatic logic sticky_next(input logic cur, input logic evt, input logic clr);
    return evt | (cur & ~clr);
  endfunction
endpackage

// File: rtl/laser_chain.sv
module laser_chain #(
  parameter int unsigned CELLS = 4,
  parameter logic [CELLS-1:0] ACTIVE_LOW = '0
) (
  input  logic [CELLS-1:0] raw_i,
  output logic             hit_o
);
  import laser_alarm_pkg::*;

  logic [CELLS:0] link;
  assign link[0] = 1'b0;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    assign link[k+1] = link[k] | cell_active(raw_i[k], ACTIVE_LOW[k]);
  end

  assign hit_o = link[CELLS];
endmodule

// File: rtl/pulse_catcher.sv
module pulse_catcher (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic sync_o
);
  logic held_q;
  logic s1_q;
  logic s2_q;

  // Set without a clock by the chain; released once the synchronised copy is seen.
  always_ff @(posedge clk or negedge rst_n or posedge hit_i) begin
    if (!rst_n)      held_q <= 1'b0;
    else if (hit_i)  held_q <= 1'b1;
    else if (s2_q)   held_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= held_q;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/laser_alarm_agg.sv
module laser_alarm_agg #(
  parameter int unsigned NUM_CHAINS      = 4,
  parameter int unsigned CELLS_PER_CHAIN = 4,
  parameter logic [NUM_CHAINS*CELLS_PER_CHAIN-1:0] CELL_ACTIVE_LOW = '0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_CHAINS*CELLS_PER_CHAIN-1:0] det_raw_i,
  input  logic                                  self_test_i,
  input  logic                                  clr_i,
  output logic                                  alarm_o,
  output logic [NUM_CHAINS-1:0]                 chain_status_o
);
  import laser_alarm_pkg::*;

  localparam int unsigned TOTAL_CELLS = NUM_CHAINS * CELLS_PER_CHAIN;

  logic [NUM_CHAINS-1:0] chain_raw_hit;
  logic [NUM_CHAINS-1:0] chain_hit;
  logic [NUM_CHAINS-1:0] sync_hit;
  logic                  all_quiet;
  logic                  alarm_q;
  logic [NUM_CHAINS-1:0] status_q;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    laser_chain #(
      .CELLS      (CELLS_PER_CHAIN),
      .ACTIVE_LOW (CELL_ACTIVE_LOW[c*CELLS_PER_CHAIN +: CELLS_PER_CHAIN])
    ) u_chain (
      .raw_i (det_raw_i[c*CELLS_PER_CHAIN +: CELLS_PER_CHAIN]),
      .hit_o (chain_raw_hit[c])
    );

    assign chain_hit[c] = chain_raw_hit[c] | self_test_i;

    pulse_catcher u_catch (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (chain_hit[c]),
      .sync_o (sync_hit[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[c] <= 1'b0;
      else        status_q[c] <= sticky_next(status_q[c], sync_hit[c], clr_i);
    end
  end

  // NOR merge of all synchronised chain outputs drives the single flag flop.
  assign all_quiet = ~|sync_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= 1'b0;
    else        alarm_q <= sticky_next(alarm_q, ~all_quiet, clr_i);
  end

  assign alarm_o        = alarm_q;
  assign chain_status_o = status_q;

  logic unused_total;
  assign unused_total = (TOTAL_CELLS == 0);
endmodule

// File: rtl/laser_alarm_agg_chk.sv
module laser_alarm_agg_chk #(
  parameter int unsigned NUM_CHAINS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_i,
  input logic                  self_test_i,
  input logic [NUM_CHAINS-1:0] sync_hit,
  input logic                  alarm_o,
  input logic [NUM_CHAINS-1:0] chain_status_o
);
  logic [1:0] st_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            st_cnt <= 2'd0;
    else if (!self_test_i) st_cnt <= 2'd0;
    else if (st_cnt != 2'd3) st_cnt <= st_cnt + 2'd1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_clear: assert (!alarm_o && chain_status_o == '0);
  end

  a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> $past(|sync_hit));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !clr_i) |=> alarm_o);

  a_r6_clean_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && sync_hit == '0) |=> (!alarm_o && chain_status_o == '0));

  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && sync_hit != '0) |=> alarm_o);

  a_r8_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((chain_status_o & $past(chain_status_o)) == $past(chain_status_o)));

  a_r9_selftest_all: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cnt == 2'd3 && self_test_i) |-> (&chain_status_o));

  a_r10_alarm_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o == (|chain_status_o));
endmodule

bind laser_alarm_agg laser_alarm_agg_chk #(.NUM_CHAINS(NUM_CHAINS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clr_i          (clr_i),
  .self_test_i    (self_test_i),
  .sync_hit       (sync_hit),
  .alarm_o        (alarm_o),
  .chain_status_o (chain_status_o)
);

// File: tb/tb_laser_alarm_agg.sv
`timescale 1ns/100ps
module tb_laser_alarm_agg;
  localparam int unsigned NC = 4;
  localparam int unsigned CP = 4;
  localparam logic [15:0] POL = 16'hAAAA; // odd-indexed cells are low-active

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] det = POL;
  logic st = 1'b0;
  logic clr = 1'b0;
  logic alarm;
  logic [3:0] status;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  laser_alarm_agg #(.NUM_CHAINS(NC), .CELLS_PER_CHAIN(CP), .CELL_ACTIVE_LOW(POL)) dut (
    .clk(clk), .rst_n(rst_n), .det_raw_i(det), .self_test_i(st), .clr_i(clr),
    .alarm_o(alarm), .chain_status_o(status));

  // {disturbed cell mask, expected chain status}
  localparam logic [19:0] VEC [8] = '{
    {16'h0001, 4'b0001},  // R2 high-active cell 0
    {16'h0002, 4'b0001},  // R3 low-active cell 1
    {16'h0080, 4'b0010},  // R3 cell 7
    {16'h0400, 4'b0100},  // R2 cell 10
    {16'h8000, 4'b1000},  // R3 cell 15
    {16'h1010, 4'b1010},  // R8 two chains
    {16'hFFFF, 4'b1111},  // R8 all chains
    {16'h0000, 4'b0000}   // R4 idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic short_pulse(input logic [15:0] mask);
    @(negedge clk);
    det = POL ^ mask;
    #1;
    det = POL;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_n(3);
    check("R1 alarm in reset", alarm, 0);
    check("R1 status in reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 alarm after reset", alarm, 0);
    check("R1 status after reset", status, 0);

    // Table walk: sub-cycle pulses (R5), capture, clean clear (R6)
    for (int v = 0; v < 8; v++) begin
      short_pulse(VEC[v][19:4]);
      wait_n(6);
      check("R2/R3/R5 alarm set", alarm, |VEC[v][3:0]);
      check("R8 status", status, VEC[v][3:0]);
      do_clear();
      wait_n(2);
      check("R6 alarm cleared", alarm, 0);
      check("R6 status cleared", status, 0);
    end

    // R4: idle held for a long time
    det = POL;
    wait_n(20);
    check("R4 idle alarm", alarm, 0);

    // R2 latency: exactly after third rising edge
    short_pulse(16'h0004);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 not yet after two edges", alarm, 0);
    @(negedge clk);
    check("R2 set after third edge", alarm, 1);

    // R6 sticky for a long time
    wait_n(30);
    check("R6 sticky alarm", alarm, 1);
    check("R6 sticky status", status, 4'b0001);

    // R7 clear coinciding with an arriving event on chain 2
    short_pulse(16'h0100);
    @(posedge clk); @(posedge clk);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R7 alarm survives clear", alarm, 1);
    check("R7 status keeps new chain", status, 4'b0100);
    wait_n(6);
    do_clear();
    wait_n(2);
    check("R6 clear after R7", alarm, 0);

    // R9 self-test
    @(negedge clk); st = 1'b1;
    wait_n(5);
    check("R9 self-test status", status, 4'b1111);
    check("R9 self-test alarm", alarm, 1);
    @(negedge clk); st = 1'b0;
    wait_n(6);
    do_clear();
    wait_n(2);
    check("R9 released and cleared", status, 0);

    // R3 long low pulse held several cycles
    @(negedge clk); det = POL ^ 16'h0020;
    wait_n(8);
    check("R3 held pulse status", status, 4'b0010);
    det = POL;
    wait_n(6);
    do_clear();
    wait_n(2);
    check("R10 alarm follows status", alarm, |status);

    // R1 reset while alarm is set
    short_pulse(16'h2000);
    wait_n(6);
    check("R1 pre-reset alarm", alarm, 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 async reset alarm", alarm, 0);
    check("R1 async reset status", status, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_n(4);
    check("R1 stays clear", alarm, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule